// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR flash and turns a stream of bus write cycles, each an address plus a data byte, into commands for the embedded program/erase engine. A command is only recognised behind a two-write unlock preamble. Once recognised, the decoder raises a one-cycle start pulse with an operation code, a target address and a data byte. It also tracks the two persistent modes, identifier read-out and unlock bypass.

Erase takes a longer path: a setup write, a second unlock preamble and a final write that chooses between whole-array erase and sector erase. Sector addresses are collected into a small queue. Each further sector write restarts a quiet window, and the erase starts only when that window runs out. The engine then drains the queue one address at a time. While the engine reports busy, the decoder ignores writes except reset and suspend.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock preamble is data AAh at an address whose low 11 bits are 555h, followed by data 55h at an address whose low 11 bits are 2AAh. Upper address bits are not compared.
- R2: A non-busy write that does not match the next expected cycle of a sequence is discarded and returns the decoder to read mode. In the sector-collect phase it also empties the sector queue.
- R3: Unlock, then A0h at 555h, then any write produces `start_o` high for exactly one cycle, in the cycle after that write. `op_o` = 1 (program) and `op_addr_o`/`op_data_o` equal that write's address and data.
- R4: Unlock, 80h at 555h, unlock, then 10h at 555h produces a one-cycle start with `op_o` = 3 (whole-array erase).
- R5: Unlock, 80h at 555h, unlock, then 30h at any address queues that address. Sector erase starts (`op_o` = 2, `op_data_o` = 30h, `op_addr_o` = queue head) WIN cycles after the last 30h write, provided no write intervenes.
- R6: Further 30h writes during collection append their addresses in arrival order and restart the window. `sec_cnt_o` gives the queue fill. `sec_addr_o` shows the oldest entry, which a high `sec_pop_i` removes.
- R7: A 30h write that finds DEPTH entries already queued is not stored and sets `ovf_o`. `ovf_o` holds until a reset command, or until the first sector write of a new erase that finds the queue not full.
- R8: A write with data F0h at any address, in any state and even while busy, returns the decoder to read mode. It clears both modes, the queue and `ovf_o`, and pulses `rst_cmd_o` for one cycle.
- R9: Unlock plus 90h at 555h sets `autosel_o`. In that mode every write except F0h is ignored.
- R10: Unlock plus 20h at 555h sets `bypass_o`. In bypass mode, A0h at any address followed by any write starts a program (`op_o` = 1), and the decoder stays in bypass. Other writes in bypass are ignored.
- R11: While `busy_i` is high, writes other than F0h and B0h are ignored. B0h pulses `suspend_o` for one cycle. When not busy, B0h is an ordinary mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write cycle strobe, one per cycle |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 8 | Write data byte |
| busy_i | input | 1 | Engine running an embedded algorithm |
| sec_pop_i | input | 1 | Engine consumes the queue head |
| start_o | output | 1 | One-cycle command launch |
| op_o | output | 2 | 1 program, 2 sector erase, 3 whole-array erase |
| op_addr_o | output | AW | Target address of the launched command |
| op_data_o | output | 8 | Data of the launched command |
| suspend_o | output | 1 | One-cycle suspend request |
| rst_cmd_o | output | 1 | One-cycle reset command seen |
| autosel_o | output | 1 | Identifier mode active |
| bypass_o | output | 1 | Unlock bypass mode active |
| sec_addr_o | output | AW | Oldest queued sector address |
| sec_cnt_o | output | clog2(DEPTH+1) | Number of queued sectors |
| ovf_o | output | 1 | Sector queue overflow seen |

## Verification
The bench targets several corner cases:
- Unlock writes with junk in the upper address bits. A design comparing full addresses would never start.
- A near-miss second unlock address followed by a valid-looking program tail. A design that does not abort would launch a program.
- More sectors than the queue holds. A design without a full guard would overwrite the head or wrap the count.
- The exact cycle the erase window expires. Off-by-one window logic shifts the start pulse.
- Identifier mode, bypass mode and busy periods, fed with full program sequences. Leaking gating would produce a spurious start.
- Reset and suspend arriving while busy. Both must still act.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_ASEL, ST_PSET,
    ST_ER1, ST_ER_UL1, ST_ER_UL2, ST_COLLECT, ST_BYP, ST_BPSET
  } st_e;

  localparam logic [10:0] ADR_A = 11'h555;
  localparam logic [10:0] ADR_B = 11'h2AA;
  localparam logic [7:0]  D_UL1 = 8'hAA;
  localparam logic [7:0]  D_UL2 = 8'h55;
  localparam logic [7:0]  D_PRG = 8'hA0;
  localparam logic [7:0]  D_ERS = 8'h80;
  localparam logic [7:0]  D_ASL = 8'h90;
  localparam logic [7:0]  D_BYP = 8'h20;
  localparam logic [7:0]  D_SEC = 8'h30;
  localparam logic [7:0]  D_CHP = 8'h10;
  localparam logic [7:0]  D_RST = 8'hF0;
  localparam logic [7:0]  D_SUS = 8'hB0;
endpackage

// File: rtl/flash_sec_queue.sv
module flash_sec_queue #(
  parameter int AW    = 24,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_addr_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  // R7: a push into a full queue must not grow it
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> (cnt_q == CW'(DEPTH)));
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW  = 24,
  parameter int WIN = 16,
  localparam int TW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          busy_i,
  input  logic          q_full_i,
  input  logic [AW-1:0] q_head_i,
  output logic          q_push_o,
  output logic          q_clr_o,
  output logic          start_o,
  output op_e           op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic          suspend_o,
  output logic          rst_cmd_o,
  output logic          autosel_o,
  output logic          bypass_o,
  output logic          ovf_o
);
  st_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic start_d, susp_d, rstc_d, ovf_d;
  op_e op_d;
  logic [AW-1:0] addr_d;
  logic [7:0] data_d;
  logic at_a, at_b;

  assign at_a = (wr_addr_i[10:0] == ADR_A);
  assign at_b = (wr_addr_i[10:0] == ADR_B);
  assign autosel_o = (st_q == ST_ASEL);
  assign bypass_o  = (st_q == ST_BYP) || (st_q == ST_BPSET);

  always_comb begin
    st_d = st_q; tmr_d = tmr_q;
    start_d = 1'b0; susp_d = 1'b0; rstc_d = 1'b0; ovf_d = ovf_o;
    op_d = op_o; addr_d = op_addr_o; data_d = op_data_o;
    q_push_o = 1'b0; q_clr_o = 1'b0;
    if (wr_en_i) begin
      if (wr_data_i == D_RST) begin
        st_d = ST_READ; q_clr_o = 1'b1; ovf_d = 1'b0; rstc_d = 1'b1;
      end else if (busy_i) begin
        susp_d = (wr_data_i == D_SUS);
      end else begin
        unique case (st_q)
          ST_READ:   st_d = (at_a && wr_data_i == D_UL1) ? ST_UL1 : ST_READ;
          ST_UL1:    st_d = (at_b && wr_data_i == D_UL2) ? ST_UL2 : ST_READ;
          ST_UL2: begin
            st_d = ST_READ;
            if (at_a) begin
              case (wr_data_i)
                D_PRG:   st_d = ST_PSET;
                D_ERS:   st_d = ST_ER1;
                D_ASL:   st_d = ST_ASEL;
                D_BYP:   st_d = ST_BYP;
                default: st_d = ST_READ;
              endcase
            end
          end
          ST_ASEL:   st_d = ST_ASEL;
          ST_PSET, ST_BPSET: begin
            start_d = 1'b1; op_d = OP_PROG; addr_d = wr_addr_i; data_d = wr_data_i;
            st_d = (st_q == ST_BPSET) ? ST_BYP : ST_READ;
          end
          ST_ER1:    st_d = (at_a && wr_data_i == D_UL1) ? ST_ER_UL1 : ST_READ;
          ST_ER_UL1: st_d = (at_b && wr_data_i == D_UL2) ? ST_ER_UL2 : ST_READ;
          ST_ER_UL2: begin
            st_d = ST_READ;
            if (wr_data_i == D_SEC) begin
              q_push_o = 1'b1; ovf_d = q_full_i; tmr_d = TW'(WIN - 1); st_d = ST_COLLECT;
            end else if (at_a && wr_data_i == D_CHP) begin
              start_d = 1'b1; op_d = OP_CHIP; addr_d = wr_addr_i; data_d = wr_data_i;
            end
          end
          ST_COLLECT: begin
            if (wr_data_i == D_SEC) begin
              q_push_o = 1'b1; tmr_d = TW'(WIN - 1);
              if (q_full_i) ovf_d = 1'b1;
            end else begin
              q_clr_o = 1'b1; st_d = ST_READ;
            end
          end
          ST_BYP:    st_d = (wr_data_i == D_PRG) ? ST_BPSET : ST_BYP;
          default:   st_d = ST_READ;
        endcase
      end
    end else if (st_q == ST_COLLECT) begin
      if (tmr_q == '0) begin
        start_d = 1'b1; op_d = OP_SECT; addr_d = q_head_i; data_d = D_SEC; st_d = ST_READ;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_READ; tmr_q <= '0; start_o <= 1'b0; op_o <= OP_NONE;
      op_addr_o <= '0; op_data_o <= '0; suspend_o <= 1'b0; rst_cmd_o <= 1'b0; ovf_o <= 1'b0;
    end else begin
      st_q <= st_d; tmr_q <= tmr_d; start_o <= start_d; op_o <= op_d;
      op_addr_o <= addr_d; op_data_o <= data_d; suspend_o <= susp_d;
      rst_cmd_o <= rstc_d; ovf_o <= ovf_d;
    end
  end

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_i && wr_data_i != D_RST) |=> ($stable(st_q) && !start_o));
  assert_suspend_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(busy_i));
  assert_reset_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == D_RST) |=> (st_q == ST_READ && rst_cmd_o && !ovf_o));
  assert_chip_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && op_o == OP_CHIP) |-> $past(st_q) == ST_ER_UL2);
  assert_sect_path_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && op_o == OP_SECT) |-> ($past(st_q) == ST_COLLECT && !$past(wr_en_i)));
  assert_asel_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (autosel_o && wr_en_i && wr_data_i != D_RST) |=> autosel_o);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DEPTH = 4,
  parameter int WIN   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          busy_i,
  input  logic          sec_pop_i,
  output logic          start_o,
  output logic [1:0]    op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic          suspend_o,
  output logic          rst_cmd_o,
  output logic          autosel_o,
  output logic          bypass_o,
  output logic [AW-1:0] sec_addr_o,
  output logic [CW-1:0] sec_cnt_o,
  output logic          ovf_o
);
  logic q_push, q_clr, q_full;
  op_e  op_w;

  assign op_o = op_w;

  flash_cmd_seq #(.AW(AW), .WIN(WIN)) u_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .busy_i,
    .q_full_i(q_full), .q_head_i(sec_addr_o), .q_push_o(q_push), .q_clr_o(q_clr),
    .start_o, .op_o(op_w), .op_addr_o, .op_data_o, .suspend_o, .rst_cmd_o,
    .autosel_o, .bypass_o, .ovf_o
  );

  flash_sec_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni, .clr_i(q_clr), .push_i(q_push), .push_addr_i(wr_addr_i),
    .pop_i(sec_pop_i), .head_o(sec_addr_o), .cnt_o(sec_cnt_o), .full_o(q_full)
  );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24, DEPTH = 4, WIN = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, busy = 0, pop = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic start_o, suspend_o, rst_cmd_o, autosel_o, bypass_o, ovf_o;
  logic [1:0] op_o;
  logic [AW-1:0] op_addr_o, sec_addr_o;
  logic [7:0] op_data_o;
  logic [CW-1:0] sec_cnt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DEPTH(DEPTH), .WIN(WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_i(busy), .sec_pop_i(pop), .start_o, .op_o, .op_addr_o, .op_data_o,
    .suspend_o, .rst_cmd_o, .autosel_o, .bypass_o, .sec_addr_o, .sec_cnt_o, .ovf_o
  );

  // behavioural reference: phase numbers, a queue and a countdown
  int m_ph, m_tmr, sz0;
  logic [AW-1:0] m_q[$];
  logic [AW-1:0] head0, m_addr;
  logic [7:0] m_data;
  logic [1:0] m_op;
  bit m_start, m_susp, m_rstc, m_ovf, clr, push;
  logic [10:0] lo;

  task automatic fire(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    m_start = 1; m_op = op; m_addr = a; m_data = d;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_q.delete(); m_tmr = 0; m_start = 0; m_op = 0; m_addr = '0;
      m_data = '0; m_susp = 0; m_rstc = 0; m_ovf = 0;
    end else begin
      sz0 = m_q.size(); head0 = (sz0 > 0) ? m_q[0] : '0;
      clr = 0; push = 0; m_start = 0; m_susp = 0; m_rstc = 0; lo = wr_addr[10:0];
      if (wr_en) begin
        if (wr_data == 8'hF0) begin m_ph = 0; clr = 1; m_ovf = 0; m_rstc = 1; end
        else if (busy) m_susp = (wr_data == 8'hB0);
        else case (m_ph)
          0: m_ph = (lo == 11'h555 && wr_data == 8'hAA) ? 1 : 0;
          1: m_ph = (lo == 11'h2AA && wr_data == 8'h55) ? 2 : 0;
          2: if (lo != 11'h555) m_ph = 0;
             else if (wr_data == 8'hA0) m_ph = 4;
             else if (wr_data == 8'h80) m_ph = 5;
             else if (wr_data == 8'h90) m_ph = 3;
             else if (wr_data == 8'h20) m_ph = 9;
             else m_ph = 0;
          3: ;
          4: begin fire(2'd1, wr_addr, wr_data); m_ph = 0; end
          5: m_ph = (lo == 11'h555 && wr_data == 8'hAA) ? 6 : 0;
          6: m_ph = (lo == 11'h2AA && wr_data == 8'h55) ? 7 : 0;
          7: if (wr_data == 8'h30) begin
               push = 1; m_ovf = (sz0 == DEPTH); m_tmr = WIN - 1; m_ph = 8;
             end else begin
               if (lo == 11'h555 && wr_data == 8'h10) fire(2'd3, wr_addr, wr_data);
               m_ph = 0;
             end
          8: if (wr_data == 8'h30) begin
               push = 1; m_tmr = WIN - 1; if (sz0 == DEPTH) m_ovf = 1;
             end else begin clr = 1; m_ph = 0; end
          9: if (wr_data == 8'hA0) m_ph = 10;
          10: begin fire(2'd1, wr_addr, wr_data); m_ph = 9; end
          default: m_ph = 0;
        endcase
      end else if (m_ph == 8) begin
        if (m_tmr == 0) begin fire(2'd2, head0, 8'h30); m_ph = 0; end
        else m_tmr--;
      end
      if (clr) m_q.delete();
      else begin
        if (pop && sz0 > 0) void'(m_q.pop_front());
        if (push && sz0 < DEPTH) m_q.push_back(wr_addr);
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    chk("R3", "start_o", start_o, m_start);
    if (m_start) begin
      chk("R4", "op_o", op_o, m_op);
      chk("R3", "op_addr_o", op_addr_o, m_addr);
      chk("R3", "op_data_o", op_data_o, m_data);
    end
    chk("R11", "suspend_o", suspend_o, m_susp);
    chk("R8", "rst_cmd_o", rst_cmd_o, m_rstc);
    chk("R9", "autosel_o", autosel_o, (m_ph == 3));
    chk("R10", "bypass_o", bypass_o, (m_ph == 9 || m_ph == 10));
    chk("R7", "ovf_o", ovf_o, m_ovf);
    chk("R6", "sec_cnt_o", sec_cnt_o, m_q.size());
    if (m_q.size() > 0) chk("R6", "sec_addr_o", sec_addr_o, m_q[0]);
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic unlock(); wr(24'h000555, 8'hAA); wr(24'h0002AA, 8'h55); endtask
  task automatic erase_pre(); unlock(); wr(24'h000555, 8'h80); unlock(); endtask
  task automatic pop_one(input logic [AW-1:0] exp);
    chk("R6", "queue order", sec_addr_o, exp);
    pop = 1; @(negedge clk); pop = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", "reset start", start_o, 0);
    chk("R9", "reset autosel", autosel_o, 0);
    chk("R6", "reset count", sec_cnt_o, 0);

    // R1 / R3: program with junk in upper unlock address bits
    wr(24'hAB0555, 8'hAA); wr(24'h3F02AA, 8'h55); wr(24'h000555, 8'hA0);
    wr(24'h012345, 8'h5A);
    chk("R1", "start after upper-bit unlock", start_o, 1);
    chk("R3", "prog op", op_o, 1);
    chk("R3", "prog addr", op_addr_o, 24'h012345);
    idle(1); chk("R3", "pulse width", start_o, 0);
    busy = 1; idle(3); busy = 0; idle(1);

    // R2: near-miss second unlock aborts
    wr(24'h000555, 8'hAA); wr(24'h0002AB, 8'h55); wr(24'h000555, 8'hA0); wr(24'h000100, 8'h11);
    chk("R2", "no start after mismatch", start_o, 0);
    idle(2);

    // R4: whole-array erase
    erase_pre(); wr(24'h000555, 8'h10);
    chk("R4", "chip op", op_o, 3);
    chk("R4", "chip start", start_o, 1);
    busy = 1; idle(2); busy = 0; idle(1);

    // R5 / R6: three sectors, window restarts
    erase_pre(); wr(24'h020000, 8'h30); idle(3);
    wr(24'h050000, 8'h30); idle(WIN - 2);
    wr(24'h070000, 8'h30);
    idle(WIN - 1);
    chk("R5", "no start before window end", start_o, 0);
    idle(1);
    chk("R5", "sector start", start_o, 1);
    chk("R5", "sector op", op_o, 2);
    chk("R5", "sector head", op_addr_o, 24'h020000);
    chk("R6", "three queued", sec_cnt_o, 3);
    busy = 1;
    pop_one(24'h020000); pop_one(24'h050000); pop_one(24'h070000);
    chk("R6", "drained", sec_cnt_o, 0);
    busy = 0; idle(1);

    // R7: overflow
    erase_pre();
    for (int i = 0; i < DEPTH + 2; i++) wr(AW'((i + 1) * 24'h010000), 8'h30);
    chk("R7", "overflow flag", ovf_o, 1);
    chk("R7", "count capped", sec_cnt_o, DEPTH);
    idle(WIN);
    chk("R7", "start after overflow", start_o, 1);
    busy = 1;
    for (int i = 0; i < DEPTH; i++) pop_one(AW'((i + 1) * 24'h010000));
    busy = 0; idle(1);
    chk("R7", "flag held", ovf_o, 1);
    erase_pre(); wr(24'h0A0000, 8'h30);
    chk("R7", "flag cleared by new erase", ovf_o, 0);

    // R2: non-30h write during collection discards the queue
    wr(24'h000000, 8'h00);
    chk("R2", "queue emptied", sec_cnt_o, 0);
    idle(WIN + 2);

    // R9 / R8: identifier mode ignores commands; F0 exits
    unlock(); wr(24'h000555, 8'h90);
    chk("R9", "autosel on", autosel_o, 1);
    unlock(); wr(24'h000555, 8'hA0); wr(24'h000200, 8'h22);
    chk("R9", "no start in autosel", start_o, 0);
    chk("R9", "still autosel", autosel_o, 1);
    wr(24'h123456, 8'hF0);
    chk("R8", "autosel off", autosel_o, 0);
    chk("R8", "rst pulse", rst_cmd_o, 1);
    idle(1);

    // R10: bypass program
    unlock(); wr(24'h000555, 8'h20);
    chk("R10", "bypass on", bypass_o, 1);
    wr(24'h000777, 8'h55);
    chk("R10", "still bypass", bypass_o, 1);
    wr(24'h000123, 8'hA0); wr(24'h000456, 8'h77);
    chk("R10", "bypass prog start", start_o, 1);
    chk("R10", "bypass prog data", op_data_o, 8'h77);
    chk("R10", "stays bypass", bypass_o, 1);
    wr(24'h000000, 8'hF0);
    chk("R10", "bypass off", bypass_o, 0);

    // R11: busy gating, suspend, reset while busy
    busy = 1;
    unlock(); wr(24'h000555, 8'hA0); wr(24'h000300, 8'h33);
    chk("R11", "no start while busy", start_o, 0);
    wr(24'h000000, 8'hB0);
    chk("R11", "suspend pulse", suspend_o, 1);
    wr(24'h000000, 8'hF0);
    chk("R8", "reset while busy", rst_cmd_o, 1);
    busy = 0; idle(1);
    wr(24'h000555, 8'hAA); wr(24'h000000, 8'hB0); wr(24'h0002AA, 8'h55);
    wr(24'h000555, 8'hA0); wr(24'h000400, 8'h44);
    chk("R11", "idle B0 aborts", start_o, 0);
    chk("R11", "no suspend idle", suspend_o, 0);

    // R8: reset during collection clears queue
    erase_pre(); wr(24'h030000, 8'h30);
    wr(24'h000000, 8'hF0);
    chk("R8", "queue cleared", sec_cnt_o, 0);
    idle(WIN + 2);
    chk("R8", "no erase after reset", start_o, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule